// File: doc/BRIEF.md
# Fetch and Decode Timing Controller

This block is the front end of a small accumulator machine's control unit. A four-bit step counter is expanded into sixteen one-hot timing strobes. The first three steps carry out the fixed instruction fetch and decode over a shared 16-bit bus:

- **Step 0:** the program counter is copied into the address register.
- **Step 1:** the word at that address is read into the instruction register, and the program counter advances.
- **Step 2:** the opcode field is decoded into eight one-hot lines, the operand address is copied into the address register, and the top bit is latched as the indirect flag.

At step 3 the controller classifies the instruction as one of four kinds: memory reference with direct addressing, memory reference with indirect addressing, register operation, or I/O operation.

The counter only moves forward on clocks where the step-enable input is high. On those same clocks the fetch and decode transfers take place; when the counter is held, nothing is transferred. Execute logic outside the block can return the counter to step 0 with a synchronous clear. Register and I/O instructions finish inside the block: at step 3 it raises a done strobe and restarts the fetch by itself.

Top module: `fetch_decode_ctl`

## Requirements
- R1: After reset the counter is at step 0 (tsig = 16'h0001), and pc, ar, ir, the latched opcode and ind are all zero, so dsig = 8'h01.
- R2: Exactly one bit of tsig is high in every cycle, and bit n is high when the counter holds step n.
- R3: On a clock where sc_inc is high and sc_clr and done are low, the counter moves from step n to step n+1, and from step 15 to step 0. When sc_inc is low and neither clear source is active, the counter holds its value.
- R4: On a clock where sc_clr is high, the counter goes to step 0 whatever the value of sc_inc. No register transfer takes place on that clock.
- R5: At step 0, bus_sel is 3'b010, which selects the program counter. When the block advances, ar_ld is high and ar takes pc.
- R6: At step 1, bus_sel is 3'b111, which selects memory. When the block advances, mem_rd, ir_ld and pc_inc are high, ir takes mem_rdata (the word at address ar), and pc increments modulo 2^AW.
- R7: At step 2, bus_sel is 3'b101, which selects the instruction register. When the block advances, ar takes ir[11:0], dsig becomes the one-hot decode of ir[14:12] (bit k high for field value k), and ind takes ir[15].
- R8: At step 3, exactly one class output is high, chosen as follows:
  - dsig[7]=0 and ind=0: cls_mem_dir
  - dsig[7]=0 and ind=1: cls_mem_ind
  - dsig[7]=1 and ind=0: cls_reg
  - dsig[7]=1 and ind=1: cls_io

  At every other step, all four class outputs are low.
- R9: At step 3 with dsig[7]=1 and the block advancing, done is high and the counter goes to step 0 on the next clock. done is low at all other times.
- R10: bus_sel is 3'b000 at steps 3 to 15. The strobes ar_ld, ir_ld, pc_inc and mem_rd are high only when sc_inc is high and sc_clr is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_inc | input | 1 | Step enable: advance the counter and perform this step's transfers |
| sc_clr | input | 1 | Return the counter to step 0 (from execute logic) |
| mem_rdata | input | DW | Memory word at address ar |
| tsig | output | 16 | One-hot timing strobes T0 to T15 |
| bus_sel | output | 3 | Bus source code |
| ar_ld | output | 1 | Address register load strobe |
| ir_ld | output | 1 | Instruction register load strobe |
| pc_inc | output | 1 | Program counter increment strobe |
| mem_rd | output | 1 | Memory read strobe |
| pc | output | AW | Program counter |
| ar | output | AW | Address register, memory address |
| ir | output | DW | Instruction register |
| dsig | output | 8 | One-hot opcode decode D0 to D7 |
| ind | output | 1 | Latched indirect bit |
| cls_mem_dir | output | 1 | Step 3: direct memory-reference instruction |
| cls_mem_ind | output | 1 | Step 3: indirect memory-reference instruction |
| cls_reg | output | 1 | Step 3: register instruction |
| cls_io | output | 1 | Step 3: I/O instruction |
| done | output | 1 | Register or I/O instruction finished; fetch restarts |

## Verification
The hardest case to reach is the wrap from step 15 to step 0. It only happens when a memory-reference instruction is left running without a clear from the execute side for twelve more advancing clocks. The stimulus therefore gives each memory instruction a clear target that rotates through several steps and "never", so some instructions run through the wrap and go straight into the next fetch. A second difficult case is a clear, or a stall, that lands on a fetch step. The stimulus overlays periodic clears and stalls that are not locked to the step count, so they hit step 0, step 1 and step 2 and show that those transfers are suppressed.

// File: rtl/fetch_decode_ctl.sv
module fetch_decode_ctl #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sc_inc,
  input  logic          sc_clr,
  input  logic [DW-1:0] mem_rdata,
  output logic [15:0]   tsig,
  output logic [2:0]    bus_sel,
  output logic          ar_ld,
  output logic          ir_ld,
  output logic          pc_inc,
  output logic          mem_rd,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] ar,
  output logic [DW-1:0] ir,
  output logic [7:0]    dsig,
  output logic          ind,
  output logic          cls_mem_dir,
  output logic          cls_mem_ind,
  output logic          cls_reg,
  output logic          cls_io,
  output logic          done
);
  localparam logic [2:0] SEL_NONE = 3'b000;
  localparam logic [2:0] SEL_PC   = 3'b010;
  localparam logic [2:0] SEL_IR   = 3'b101;
  localparam logic [2:0] SEL_MEM  = 3'b111;

  logic [3:0]    sc;
  logic [2:0]    op;
  logic          go;
  logic [DW-1:0] bus;

  assign tsig = 16'h0001 << sc;
  assign dsig = 8'h01 << op;
  assign go   = sc_inc & ~sc_clr;

  assign bus_sel = tsig[0] ? SEL_PC  :
                   tsig[1] ? SEL_MEM :
                   tsig[2] ? SEL_IR  : SEL_NONE;

  always_comb begin
    case (bus_sel)
      SEL_PC:  bus = DW'(pc);
      SEL_MEM: bus = mem_rdata;
      SEL_IR:  bus = ir;
      default: bus = '0;
    endcase
  end

  assign ar_ld  = go & (tsig[0] | tsig[2]);
  assign ir_ld  = go & tsig[1];
  assign pc_inc = go & tsig[1];
  assign mem_rd = go & tsig[1];

  assign cls_mem_dir = tsig[3] & ~dsig[7] & ~ind;
  assign cls_mem_ind = tsig[3] & ~dsig[7] &  ind;
  assign cls_reg     = tsig[3] &  dsig[7] & ~ind;
  assign cls_io      = tsig[3] &  dsig[7] &  ind;
  assign done        = go & tsig[3] & dsig[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc  <= '0;
      pc  <= '0;
      ar  <= '0;
      ir  <= '0;
      op  <= '0;
      ind <= 1'b0;
    end else begin
      if (sc_clr || done) sc <= '0;
      else if (sc_inc)    sc <= sc + 4'd1;
      if (ar_ld)  ar <= bus[AW-1:0];
      if (ir_ld)  ir <= bus;
      if (pc_inc) pc <= pc + AW'(1);
      if (go && tsig[2]) begin
        op  <= ir[14:12];
        ind <= ir[15];
      end
    end
  end
endmodule

module fetch_decode_ctl_chk #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sc_inc,
  input logic          sc_clr,
  input logic [15:0]   tsig,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] ir,
  input logic          ind,
  input logic          cls_mem_dir,
  input logic          cls_mem_ind,
  input logic          cls_reg,
  input logic          cls_io,
  input logic          done
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tsig) == 1);
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tsig[15] && sc_inc && !sc_clr |=> tsig[0]);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_inc && !sc_clr && !done |=> $stable(tsig));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_clr |=> tsig[0]);
  p_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tsig[1] && sc_inc && !sc_clr |=> (pc - $past(pc)) == AW'(1));
  p_ind_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tsig[2] && sc_inc && !sc_clr |=> ind == $past(ir[15]));
  p_class_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tsig[3] |-> !(cls_mem_dir || cls_mem_ind || cls_reg || cls_io));
  p_class_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tsig[3] |-> $onehot({cls_mem_dir, cls_mem_ind, cls_reg, cls_io}));
  p_done_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> tsig[0]);
endmodule

bind fetch_decode_ctl fetch_decode_ctl_chk #(.AW(AW), .DW(DW)) chk (
  .clk(clk), .rst_n(rst_n), .sc_inc(sc_inc), .sc_clr(sc_clr), .tsig(tsig),
  .pc(pc), .ir(ir), .ind(ind), .cls_mem_dir(cls_mem_dir),
  .cls_mem_ind(cls_mem_ind), .cls_reg(cls_reg), .cls_io(cls_io), .done(done)
);

// File: tb/fetch_decode_ctl_test.sv
`timescale 1ns/1ps
module fetch_decode_ctl_test;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sc_inc = 1'b0;
  logic sc_clr = 1'b0;
  logic [DW-1:0] mem_rdata;
  logic [15:0] tsig;
  logic [2:0] bus_sel;
  logic ar_ld, ir_ld, pc_inc, mem_rd;
  logic [AW-1:0] pc, ar;
  logic [DW-1:0] ir;
  logic [7:0] dsig;
  logic ind, cls_mem_dir, cls_mem_ind, cls_reg, cls_io, done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [DW-1:0] mem [0:63];
  assign mem_rdata = mem[ar[5:0]];

  int msc = 0, mpc = 0, mar = 0, mir = 0, mop = 0, mind = 0;

  always #2 clk = ~clk;

  fetch_decode_ctl #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .sc_inc(sc_inc), .sc_clr(sc_clr),
    .mem_rdata(mem_rdata), .tsig(tsig), .bus_sel(bus_sel), .ar_ld(ar_ld),
    .ir_ld(ir_ld), .pc_inc(pc_inc), .mem_rd(mem_rd), .pc(pc), .ar(ar),
    .ir(ir), .dsig(dsig), .ind(ind), .cls_mem_dir(cls_mem_dir),
    .cls_mem_ind(cls_mem_ind), .cls_reg(cls_reg), .cls_io(cls_io), .done(done)
  );

  function automatic bit m_go();
    return sc_inc && !sc_clr;
  endfunction

  function automatic bit m_done();
    return m_go() && msc == 3 && mop == 7;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      msc = 0; mpc = 0; mar = 0; mir = 0; mop = 0; mind = 0;
    end else begin
      int old_sc, rd;
      bit g, dn;
      old_sc = msc;
      g = m_go();
      dn = m_done();
      rd = mem[mar % 64];
      if (sc_clr || dn) msc = 0;
      else if (sc_inc) msc = (msc + 1) % 16;
      if (g) begin
        case (old_sc)
          0: mar = mpc;
          1: begin mir = rd; mpc = (mpc + 1) % 4096; end
          2: begin mar = mir % 4096; mop = (mir >> 12) % 8; mind = (mir >> 15) % 2; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string nm, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit g, t3, d7;
    int sel;
    g = m_go();
    t3 = (msc == 3);
    d7 = (mop == 7);
    sel = (msc == 0) ? 2 : (msc == 1) ? 7 : (msc == 2) ? 5 : 0;
    chk("R2", "tsig", int'(tsig), 1 << msc);
    chk("R10", "bus_sel", int'(bus_sel), sel);
    chk("R5", "ar_ld", int'(ar_ld), int'(g && (msc == 0 || msc == 2)));
    chk("R6", "ir_ld", int'(ir_ld), int'(g && msc == 1));
    chk("R6", "pc_inc", int'(pc_inc), int'(g && msc == 1));
    chk("R6", "mem_rd", int'(mem_rd), int'(g && msc == 1));
    chk("R6", "pc", int'(pc), mpc);
    chk("R5", "ar", int'(ar), mar);
    chk("R6", "ir", int'(ir), mir);
    chk("R7", "dsig", int'(dsig), 1 << mop);
    chk("R7", "ind", int'(ind), mind);
    chk("R8", "cls_mem_dir", int'(cls_mem_dir), int'(t3 && !d7 && mind == 0));
    chk("R8", "cls_mem_ind", int'(cls_mem_ind), int'(t3 && !d7 && mind == 1));
    chk("R8", "cls_reg", int'(cls_reg), int'(t3 && d7 && mind == 0));
    chk("R8", "cls_io", int'(cls_io), int'(t3 && d7 && mind == 1));
    chk("R9", "done", int'(done), int'(m_done()));
  endtask

  initial begin
    #(NCYC * 4 + 2000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int clr_target;
    int instr;
    for (int i = 0; i < 64; i++) begin
      case (i % 5)
        0: mem[i] = 16'h1000 | 16'(i);
        1: mem[i] = 16'h7000 | 16'(1 << (i % 12));
        2: mem[i] = 16'hF000 | 16'(i * 7);
        3: mem[i] = 16'hA000 | 16'(i * 3);
        default: mem[i] = 16'h6000 | 16'(i * 5);
      endcase
    end
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "tsig", int'(tsig), 1);
    chk("R1", "pc", int'(pc), 0);
    chk("R1", "ar", int'(ar), 0);
    chk("R1", "ir", int'(ir), 0);
    chk("R1", "dsig", int'(dsig), 1);
    chk("R1", "ind", int'(ind), 0);
    rst_n = 1'b1;
    instr = 0;
    clr_target = 4;
    for (int c = 0; c < NCYC; c++) begin
      // R3: periodic stalls; R4: clears that land on any step
      sc_inc = ((c % 11) != 7) && !(c > 2000 && c < 2010);
      sc_clr = 1'b0;
      if ((c % 29) == 13) sc_clr = 1'b1;
      if (msc >= 4 && msc == clr_target && sc_inc) sc_clr = 1'b1;
      if (msc == 3 && sc_inc && !sc_clr) begin
        instr++;
        case (instr % 4)
          0: clr_target = 4;
          1: clr_target = 7;
          2: clr_target = 12;
          default: clr_target = 99;   // R3: let it wrap T15 to T0
        endcase
      end
      #1;
      compare_all();
      @(negedge clk);
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule